// File: doc/BRIEF.md
# DMA Request and Acknowledge Controller

This block holds the request-handling logic of one DMA channel that moves operands between a peripheral and memory. It watches a request line from the peripheral and starts bus cycles through a minimal start/terminate handshake. While a cycle is open it asserts an acknowledge toward the peripheral. A configuration bit selects how the request line is read. As a level, the line keeps the channel issuing cycles back to back for as long as it stays high. As an edge, each rising transition is worth exactly one transfer.

Software loads the total operand count of the buffer chain and the operand count of one buffer. Each finished transfer counts both down. When a buffer is used up, a sticky done flag is raised and the buffer counter reloads. A request that arrives once the chain is empty starts nothing and raises a sticky out-of-buffers flag. Software can hold the channel with a suspend input, for example after a done flag, so that it never reaches the out-of-buffers condition. Software can also switch the channel off with an enable input. Address generation, arbitration and the bus protocol itself are outside this block.

Top module: `dma_req_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `bus_start`, `per_ack`, `sts_done` and `sts_oob` are 0 and `ops_left` is 0.
- R2: With `cfg_level`=1, a cycle is started whenever `dreq` is sampled high at a rising edge on which the channel is idle or on which `bus_ta` ends the open cycle. The edge that ends a cycle with `dreq` low therefore makes that cycle the last one.
- R3: `bus_start` is high for exactly the first clock of each bus cycle. `per_ack` is high from that clock up to and including the clock in which `bus_ta` is sampled high. A transfer completes at the edge where `per_ack` and `bus_ta` are both 1.
- R4: With `cfg_level`=0, each 0-to-1 change of `dreq` between two sampling edges produces exactly one transfer. A rising change seen while a cycle is open is held pending and started no earlier than the edge that ends that cycle.
- R5: A `chain_load` pulse sets `ops_left` to `chain_ops` and the buffer length to `buf_ops` (`buf_ops` ≥ 1). Otherwise each completed transfer lowers `ops_left` by one.
- R6: When a completed transfer uses the last operand of the current buffer, `sts_done` goes high in the next clock and the buffer count reloads from `buf_ops`.
- R7: A request seen while idle with `ops_left`=0 starts no cycle and sets `sts_oob`. In edge mode it also consumes the pending request. No cycle is ever started while `ops_left` is 0.
- R8: While `cfg_suspend`=1 no new cycle starts, and an open cycle still runs to its `bus_ta`. After suspend is released, a request that is still pending is started.
- R9: While `cfg_enable`=0 no cycle starts, any pending edge request is discarded, and rising edges of `dreq` are ignored.
- R10: `sts_done` and `sts_oob` stay high until cleared by a one-clock pulse on `clr_done` or `clr_oob` respectively. When a set and a clear of the same flag fall in the same clock, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Channel accepts requests when 1 |
| cfg_level | input | 1 | 1 = level-sensitive request, 0 = edge-sensitive |
| cfg_suspend | input | 1 | Hold: no new cycles start while 1 |
| chain_load | input | 1 | Load pulse for the chain and buffer counts |
| chain_ops | input | CNT_W | Operands in the whole buffer chain |
| buf_ops | input | CNT_W | Operands per buffer (at least 1) |
| dreq | input | 1 | Request from the peripheral |
| bus_ta | input | 1 | Transfer acknowledge that ends the open bus cycle |
| bus_start | output | 1 | One-clock strobe opening a bus cycle |
| per_ack | output | 1 | Acknowledge to the peripheral for the open cycle |
| ops_left | output | CNT_W | Operands still to move in the chain |
| sts_done | output | 1 | Sticky buffer-complete flag |
| sts_oob | output | 1 | Sticky out-of-buffers error flag |
| clr_done | input | 1 | Write-one-to-clear pulse for `sts_done` |
| clr_oob | input | 1 | Write-one-to-clear pulse for `sts_oob` |

## Verification
The cases that need the most care are a completing transfer and a new request that land on the same edge. These are the `bus_ta` edge that also samples `dreq` in level mode, and a held-high level request that keeps setting `sts_oob` in the same clock as a `clr_oob` pulse. Both are provoked directly. A level request is dropped exactly while the third acknowledge is open. A clear is pulsed while the empty chain is still being requested. Long random runs then mix modes, wait states, suspends and clears so that these collisions occur at random. Each clock, every output is compared with a cycle-level reference model computed in the bench from the requirements.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } chan_state_e;

    typedef struct packed {
        logic enable;
        logic level;
        logic suspend;
    } chan_cfg_t;

    localparam int unsigned FLAG_DONE = 0;
    localparam int unsigned FLAG_OOB  = 1;
    localparam int unsigned N_FLAGS   = 2;

    // Request presented to the sequencer for the chosen sensitivity.
    function automatic logic req_want(input logic level, input logic line,
                                      input logic pend, input logic rise);
        return level ? line : (pend | rise);
    endfunction

endpackage

// File: rtl/req_sampler.sv
module req_sampler
    import dma_req_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    input  logic      dreq,
    input  logic      consume,
    output logic      want
);
    logic prev_q;
    logic pend_q;
    logic rise;
    logic pend_d;

    assign rise = dreq & ~prev_q;
    assign want = req_want(cfg.level, dreq, pend_q, rise);

    // A rise that lands on the same edge as a consumed pending one stays held.
    always_comb begin
        if (!cfg.enable || cfg.level) begin
            pend_d = 1'b0;
        end else if (consume) begin
            pend_d = pend_q & rise;
        end else begin
            pend_d = pend_q | rise;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= dreq;
            pend_q <= pend_d;
        end
    end

    AST_PEND_DROP_OFF: assert property (@(posedge clk) disable iff (rst)
        !cfg.enable |=> !pend_q); // R9

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import dma_req_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    input  logic      want,
    input  logic      bus_ta,
    input  logic      ops_zero,
    input  logic      ops_one,
    output logic      consume,
    output logic      complete,
    output logic      oob_hit,
    output logic      bus_start,
    output logic      per_ack
);
    chan_state_e state_q;
    chan_state_e state_d;
    logic        start_q;
    logic        can_go;
    logic        slot;
    logic        avail;
    logic        start;

    assign can_go   = cfg.enable & ~cfg.suspend;
    assign complete = (state_q == ST_BUSY) & bus_ta;
    assign slot     = (state_q == ST_IDLE) | complete;
    // Operands left after the completion on this edge, if any.
    assign avail    = complete ? ~ops_one : ~ops_zero;
    assign start    = slot & can_go & want & avail;
    assign oob_hit  = (state_q == ST_IDLE) & can_go & want & ops_zero;
    assign consume  = start | oob_hit;

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_BUSY;
        end else if (complete) begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= start;
        end
    end

    assign bus_start = start_q;
    assign per_ack   = (state_q == ST_BUSY);

    AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (per_ack && !bus_ta) |=> (per_ack && !bus_start)); // R3
    AST_SUSPEND_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        cfg.suspend |=> !bus_start); // R8
    AST_DISABLE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        !cfg.enable |=> !bus_start); // R9

endmodule

// File: rtl/chain_counter.sv
module chain_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] chain_ops,
    input  logic [CNT_W-1:0] buf_ops,
    input  logic             complete,
    output logic [CNT_W-1:0] ops_left,
    output logic             ops_zero,
    output logic             ops_one,
    output logic             done_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] ops_q;
    logic [CNT_W-1:0] buf_q;
    logic [CNT_W-1:0] blen_q;
    logic             buf_last;

    assign buf_last = (buf_q == ONE);
    assign done_evt = complete & ~load & buf_last;
    assign ops_zero = (ops_q == '0);
    assign ops_one  = (ops_q == ONE);
    assign ops_left = ops_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ops_q  <= '0;
            buf_q  <= '0;
            blen_q <= '0;
        end else if (load) begin
            ops_q  <= chain_ops;
            buf_q  <= buf_ops;
            blen_q <= buf_ops;
        end else if (complete) begin
            ops_q <= ops_q - ONE;
            buf_q <= buf_last ? blen_q : (buf_q - ONE);
        end
    end

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (complete && !load) |=> (ops_left == $past(ops_left) - ONE)); // R5
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> (ops_left == $past(chain_ops))); // R5

endmodule

// File: rtl/status_flags.sv
module status_flags #(
    parameter int unsigned NF = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set_evt,
    input  logic [NF-1:0] clr_evt,
    output logic [NF-1:0] flags
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
            end else begin
                flag_q <= set_evt[i] | (flag_q & ~clr_evt[i]);
            end
        end
        assign flags[i] = flag_q;

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            (flag_q && !clr_evt[i]) |=> flag_q); // R10
        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_evt[i] |=> flag_q); // R10
    end

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
    import dma_req_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic             cfg_level,
    input  logic             cfg_suspend,
    input  logic             chain_load,
    input  logic [CNT_W-1:0] chain_ops,
    input  logic [CNT_W-1:0] buf_ops,
    input  logic             dreq,
    input  logic             bus_ta,
    output logic             bus_start,
    output logic             per_ack,
    output logic [CNT_W-1:0] ops_left,
    output logic             sts_done,
    output logic             sts_oob,
    input  logic             clr_done,
    input  logic             clr_oob
);
    chan_cfg_t        cfg;
    logic             want;
    logic             consume;
    logic             complete;
    logic             oob_hit;
    logic             ops_zero;
    logic             ops_one;
    logic             done_evt;
    logic [N_FLAGS-1:0] set_vec;
    logic [N_FLAGS-1:0] clr_vec;
    logic [N_FLAGS-1:0] flag_vec;

    assign cfg = '{enable: cfg_enable, level: cfg_level, suspend: cfg_suspend};

    req_sampler u_sampler (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .dreq    (dreq),
        .consume (consume),
        .want    (want)
    );

    xfer_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .want      (want),
        .bus_ta    (bus_ta),
        .ops_zero  (ops_zero),
        .ops_one   (ops_one),
        .consume   (consume),
        .complete  (complete),
        .oob_hit   (oob_hit),
        .bus_start (bus_start),
        .per_ack   (per_ack)
    );

    chain_counter #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .load      (chain_load),
        .chain_ops (chain_ops),
        .buf_ops   (buf_ops),
        .complete  (complete),
        .ops_left  (ops_left),
        .ops_zero  (ops_zero),
        .ops_one   (ops_one),
        .done_evt  (done_evt)
    );

    always_comb begin
        set_vec            = '0;
        clr_vec            = '0;
        set_vec[FLAG_DONE] = done_evt;
        set_vec[FLAG_OOB]  = oob_hit;
        clr_vec[FLAG_DONE] = clr_done;
        clr_vec[FLAG_OOB]  = clr_oob;
    end

    status_flags #(.NF(N_FLAGS)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_evt (set_vec),
        .clr_evt (clr_vec),
        .flags   (flag_vec)
    );

    assign sts_done = flag_vec[FLAG_DONE];
    assign sts_oob  = flag_vec[FLAG_OOB];

    AST_START_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        bus_start |-> (ops_left != '0)); // R7
    AST_START_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        bus_start |-> per_ack); // R3
    AST_LEVEL_STOP: assert property (@(posedge clk) disable iff (rst)
        (cfg_level && per_ack && bus_ta && !dreq) |=> !bus_start); // R2

endmodule

// File: tb/dma_req_ctrl_tb.sv
module dma_req_ctrl_tb;
    localparam int unsigned CNT_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_enable = 1'b0, cfg_level = 1'b0, cfg_suspend = 1'b0;
    logic chain_load = 1'b0;
    logic [CNT_W-1:0] chain_ops = '0, buf_ops = '0;
    logic dreq = 1'b0, bus_ta = 1'b0;
    logic clr_done = 1'b0, clr_oob = 1'b0;
    logic bus_start, per_ack, sts_done, sts_oob;
    logic [CNT_W-1:0] ops_left;

    int n_checks = 0;
    int n_errors = 0;
    int n_starts = 0;
    bit auto_ta = 1'b0;

    // reference model state
    bit m_busy, m_start, m_prev, m_pend, m_done, m_oob;
    logic [CNT_W-1:0] m_ops, m_buf, m_blen;

    always #2.5 clk = ~clk;

    dma_req_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_level(cfg_level),
        .cfg_suspend(cfg_suspend), .chain_load(chain_load), .chain_ops(chain_ops),
        .buf_ops(buf_ops), .dreq(dreq), .bus_ta(bus_ta), .bus_start(bus_start),
        .per_ack(per_ack), .ops_left(ops_left), .sts_done(sts_done),
        .sts_oob(sts_oob), .clr_done(clr_done), .clr_oob(clr_oob)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Next state of the model from the inputs sampled at this edge.
    task automatic model_step();
        bit rise, cango, want, comp, avail, start, oobh, cons, donee;
        if (rst) begin
            m_busy = 0; m_start = 0; m_prev = 0; m_pend = 0;
            m_done = 0; m_oob = 0; m_ops = '0; m_buf = '0; m_blen = '0;
            return;
        end
        rise  = dreq && !m_prev;
        cango = cfg_enable && !cfg_suspend;
        want  = cfg_level ? dreq : (m_pend || rise);
        comp  = m_busy && bus_ta;
        avail = comp ? (m_ops != 1) : (m_ops != 0);
        start = (!m_busy || comp) && cango && want && avail;
        oobh  = !m_busy && cango && want && (m_ops == 0);
        cons  = start || oobh;
        donee = comp && !chain_load && (m_buf == 1);
        if (!cfg_enable || cfg_level) m_pend = 0;
        else if (cons) m_pend = m_pend && rise;
        else m_pend = m_pend || rise;
        m_prev = dreq;
        if (chain_load) begin
            m_ops = chain_ops; m_buf = buf_ops; m_blen = buf_ops;
        end else if (comp) begin
            m_ops = m_ops - 1;
            m_buf = (m_buf == 1) ? m_blen : m_buf - 1;
        end
        m_done  = donee || (m_done && !clr_done);
        m_oob   = oobh || (m_oob && !clr_oob);
        m_busy  = start ? 1'b1 : (comp ? 1'b0 : m_busy);
        m_start = start;
    endtask

    // One clock: update the model at the edge, compare after it, return at negedge.
    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        if (bus_start) n_starts++;
        chk(bus_start === m_start, "R3 bus_start", int'(bus_start), int'(m_start));
        chk(per_ack === m_busy, "R3 per_ack", int'(per_ack), int'(m_busy));
        chk(ops_left === m_ops, "R5 ops_left", int'(ops_left), int'(m_ops));
        chk(sts_done === m_done, "R6 sts_done", int'(sts_done), int'(m_done));
        chk(sts_oob === m_oob, "R7 sts_oob", int'(sts_oob), int'(m_oob));
        @(negedge clk);
        chain_load = 0; clr_done = 0; clr_oob = 0;
        if (auto_ta) bus_ta = m_busy;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic load(input int c, input int b);
        chain_ops = CNT_W'(c); buf_ops = CNT_W'(b); chain_load = 1;
        tick();
    endtask

    task automatic pulse();
        dreq = 1; tick(); dreq = 0; tick();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #1000000;
        n_checks++; n_errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        int s0, s1;
        void'($urandom(32'd2024));
        @(negedge clk);
        ticks(3);
        // R1: reset state
        chk(bus_start === 0 && per_ack === 0, "R1 idle outputs", int'(bus_start | per_ack), 0);
        chk(sts_done === 0 && sts_oob === 0, "R1 flags", int'(sts_done | sts_oob), 0);
        chk(ops_left === 0, "R1 ops_left", int'(ops_left), 0);
        rst = 0; cfg_enable = 1;
        tick();
        chk(per_ack === 0 && ops_left === 0, "R1 after release", int'(ops_left), 0);

        // R2: level mode, request dropped during third acknowledge
        load(10, 4);
        cfg_level = 1; auto_ta = 1; s0 = n_starts;
        dreq = 1;
        while (n_starts - s0 < 3) tick();
        dreq = 0;
        ticks(5);
        chk(n_starts - s0 == 3, "R2 exact stop", n_starts - s0, 3);
        chk(ops_left == 7, "R5 three decrements", int'(ops_left), 7);
        chk(sts_done == 0, "R6 buffer not yet done", int'(sts_done), 0);

        // R4: edge mode, one transfer per pulse, one pulse while busy
        cfg_level = 0; auto_ta = 0; bus_ta = 0; s0 = n_starts;
        pulse();
        pulse();               // rises while first cycle still open
        ticks(2);
        bus_ta = 1; tick(); bus_ta = 0;
        ticks(2);
        bus_ta = 1; tick(); bus_ta = 0;
        auto_ta = 1;
        pulse();
        ticks(4);
        chk(n_starts - s0 == 3, "R4 one per pulse", n_starts - s0, 3);
        chk(ops_left == 4, "R5 edge decrements", int'(ops_left), 4);
        chk(sts_done == 1, "R6 done after fourth", int'(sts_done), 1);
        clr_done = 1; tick();
        chk(sts_done == 0, "R10 clear done", int'(sts_done), 0);

        // R7 + R10: chain exhaustion with level request held, clear collides
        load(2, 1);
        cfg_level = 1; s0 = n_starts; dreq = 1;
        ticks(8);
        chk(n_starts - s0 == 2, "R7 chain length", n_starts - s0, 2);
        chk(sts_oob == 1, "R7 oob set", int'(sts_oob), 1);
        chk(ops_left == 0, "R7 empty", int'(ops_left), 0);
        clr_oob = 1; tick();
        chk(sts_oob == 1, "R10 set wins", int'(sts_oob), 1);
        dreq = 0; tick();
        clr_oob = 1; tick();
        chk(sts_oob == 0, "R10 clear oob", int'(sts_oob), 0);

        // R8: suspend holds a pending edge request
        load(5, 5);
        cfg_level = 0; cfg_suspend = 1; s0 = n_starts;
        pulse(); ticks(4);
        chk(n_starts == s0, "R8 suspended", n_starts - s0, 0);
        cfg_suspend = 0; ticks(4);
        chk(n_starts - s0 == 1, "R8 resume pending", n_starts - s0, 1);

        // R9: disabling discards a pending request
        cfg_suspend = 1; s1 = n_starts;
        pulse();
        cfg_enable = 0; tick();
        pulse();
        cfg_enable = 1; cfg_suspend = 0; ticks(5);
        chk(n_starts == s1, "R9 pending discarded", n_starts - s1, 0);
        chk(ops_left == 4, "R9 ops unchanged", int'(ops_left), 4);

        // random phase, compared against the model every clock
        for (int c = 0; c < 6000; c++) begin
            if (c % 250 == 0) cfg_level = $urandom_range(0, 1);
            if (cfg_level) begin
                if ($urandom_range(0, 7) == 0) dreq = ~dreq;
            end else dreq = ($urandom_range(0, 2) == 0);
            auto_ta = 0;
            bus_ta = m_busy && ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 30) == 0) cfg_suspend = ~cfg_suspend;
            cfg_enable = ($urandom_range(0, 60) != 0);
            clr_done = ($urandom_range(0, 11) == 0);
            clr_oob  = ($urandom_range(0, 11) == 0);
            if ($urandom_range(0, 40) == 0) begin
                chain_ops = CNT_W'($urandom_range(0, 12));
                buf_ops = CNT_W'($urandom_range(1, 5));
                chain_load = 1;
            end
            @(posedge clk);
            model_step();
            #1;
            if (bus_start) n_starts++;
            chk(bus_start === m_start, "R2 R4 R8 R9 start", int'(bus_start), int'(m_start));
            chk(per_ack === m_busy, "R3 ack", int'(per_ack), int'(m_busy));
            chk(ops_left === m_ops, "R5 count", int'(ops_left), int'(m_ops));
            chk(sts_done === m_done, "R6 R10 done", int'(sts_done), int'(m_done));
            chk(sts_oob === m_oob, "R7 R10 oob", int'(sts_oob), int'(m_oob));
            @(negedge clk);
            chain_load = 0; clr_done = 0; clr_oob = 0;
        end
        summary();
    end
endmodule